// File: doc/BRIEF.md
# Transmit Collision Statistics Counters

This block keeps two transmit statistics counters for an Ethernet MAC. One counts frames that went out successfully after two to fifteen collisions. The other counts frames that were given up because the collision retry limit was reached. The transmit engine reports each finished frame with one strobe. With that strobe it gives the collision count seen, an underrun flag and a retry-limit flag. The block classifies the frame and updates the counters.

Software reads a counter through a simple strobe-and-address read port. The read data is returned in the same cycle. The read also clears the counter at the next clock edge, so no event is lost between the read and the clear. A counter stops at all ones instead of wrapping.

Two control inputs support test. While `ctl_wr_allow` is high, software may load a counter through the write port. A rising edge on `ctl_inc_stats` adds one to both counters.

Top module: `txcol_stats`

## Requirements
- R1: The multiple-collision counter is 18 bits wide and is read at byte address 0x24. In the 32-bit read word, bits 31:18 are always zero. On a write, bits 31:18 of the data are discarded.
- R2: At a `tx_done` strobe, the multiple-collision counter adds one when all of these hold: `tx_col_cnt` is between 2 and 15 inclusive, `tx_underrun` is low and `tx_retry_lim` is low.
- R3: A frame with fewer than 2 or more than 15 collisions does not change the multiple-collision counter. Neither does a frame with underrun or retry-limit set, nor any cycle without `tx_done`.
- R4: A counter that holds all ones stays at all ones on further increments. This applies to both counters.
- R5: A read returns the counter value in the same cycle and sets the counter to zero at the next clock edge.
- R6: A write has no effect while `ctl_wr_allow` is low.
- R7: A rising edge of `ctl_inc_stats` adds one to both counters, once. Holding the bit high adds nothing more. A frame event and a test increment in the same cycle add two, still saturating.
- R8: After reset both counters read zero.
- R9: A read in the same cycle as an increment returns the value from before the increment. The counter is then left at the increment amount, so the count is not lost.
- R10: The excessive-collision counter is 10 bits wide and is read at byte address 0x28. It adds one for each `tx_done` with `tx_retry_lim` high. Saturation, clear-on-read and test features work as for the other counter.
- R11: A permitted write takes priority over a frame event, a test increment and a read to the same counter in the same cycle. The counter takes the written value.
- R12: A read at any address other than 0x24 or 0x28 returns zero and leaves both counters unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_done | input | 1 | Frame completion strobe |
| tx_col_cnt | input | 5 | Collisions seen by the frame |
| tx_underrun | input | 1 | Frame ended with a transmit underrun |
| tx_retry_lim | input | 1 | Frame abandoned at the retry limit |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 8 | Read byte address |
| rd_data | output | 32 | Read data, valid in the cycle of `rd_en` |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte address |
| wr_data | input | 32 | Write data |
| ctl_wr_allow | input | 1 | Test control: enables counter writes |
| ctl_inc_stats | input | 1 | Test control: rising edge increments all counters |

## Verification
`rd_data` is combinational, so a read result is due in the same cycle as `rd_en`. A frame event, write, test edge or clear takes effect at the next rising edge, so it shows up on a read made one cycle later. The bench drives inputs just after the falling edge and samples `rd_data` 1 ns later, before the rising edge. Its reference model is advanced only once that sample is taken, which keeps the pre-edge value separate from the post-edge value, as R9 requires.

// File: rtl/txcol_stats_pkg.sv
package txcol_stats_pkg;

  // Classified outcome of one finished frame
  typedef struct packed {
    logic multi;   // sent after 2..15 collisions
    logic excess;  // abandoned at the retry limit
  } frame_evt_t;

  // Saturating add on a counter of up to 32 bits; maxv is its all-ones value
  function automatic logic [31:0] sat_add(input logic [31:0] val,
                                          input logic [1:0]  amt,
                                          input logic [31:0] maxv);
    logic [32:0] sum;
    sum = {1'b0, val} + {31'd0, amt};
    return (sum > {1'b0, maxv}) ? maxv : sum[31:0];
  endfunction

endpackage

// File: rtl/txcol_classify.sv
module txcol_classify
  import txcol_stats_pkg::*;
#(
  parameter int COL_W  = 5,
  parameter int COL_LO = 2,
  parameter int COL_HI = 15
) (
  input  logic             tx_done,
  input  logic [COL_W-1:0] tx_col_cnt,
  input  logic             tx_underrun,
  input  logic             tx_retry_lim,
  output frame_evt_t       evt
);

  localparam logic [COL_W-1:0] LO = COL_W'(COL_LO);
  localparam logic [COL_W-1:0] HI = COL_W'(COL_HI);

  logic in_band;
  logic clean;

  always_comb begin
    in_band    = (tx_col_cnt >= LO) && (tx_col_cnt <= HI);
    clean      = !tx_underrun && !tx_retry_lim;
    evt.multi  = tx_done && in_band && clean;
    evt.excess = tx_done && tx_retry_lim;
  end

endmodule

// File: rtl/txcol_sat_ctr.sv
module txcol_sat_ctr
  import txcol_stats_pkg::*;
#(
  parameter int              W      = 18,
  parameter int              ADDR_W = 8,
  parameter logic [ADDR_W-1:0] ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt,
  input  logic              tst_pulse,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              wr_ok,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_val,
  output logic [W-1:0]      cnt,
  output logic              rd_hit,
  output logic              wr_hit
);

  localparam logic [31:0] MAXV = 32'((64'd1 << W) - 64'd1);

  logic [1:0]   amt;
  logic [W-1:0] cnt_nxt;

  assign rd_hit = rd_en && (rd_addr == ADDR);
  assign wr_hit = wr_ok && (wr_addr == ADDR);
  assign amt    = {1'b0, evt} + {1'b0, tst_pulse};

  // write > read-clear (keeping same-cycle increments) > increment
  always_comb begin
    if (wr_hit)
      cnt_nxt = wr_val;
    else if (rd_hit)
      cnt_nxt = W'(sat_add(32'd0, amt, MAXV));
    else
      cnt_nxt = W'(sat_add(32'(cnt), amt, MAXV));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

endmodule

// File: rtl/txcol_rdmux.sv
module txcol_rdmux #(
  parameter int DATA_W  = 32,
  parameter int MULTI_W = 18,
  parameter int EXC_W   = 10
) (
  input  logic               multi_hit,
  input  logic [MULTI_W-1:0] multi_cnt,
  input  logic               exc_hit,
  input  logic [EXC_W-1:0]   exc_cnt,
  output logic [DATA_W-1:0]  rd_data
);

  always_comb begin
    if (multi_hit)    rd_data = DATA_W'(multi_cnt);
    else if (exc_hit) rd_data = DATA_W'(exc_cnt);
    else              rd_data = '0;
  end

endmodule

// File: rtl/txcol_stats.sv
module txcol_stats
  import txcol_stats_pkg::*;
#(
  parameter int                DATA_W     = 32,
  parameter int                ADDR_W     = 8,
  parameter int                COL_W      = 5,
  parameter int                MULTI_W    = 18,
  parameter int                EXC_W      = 10,
  parameter logic [ADDR_W-1:0] MULTI_ADDR = 8'h24,
  parameter logic [ADDR_W-1:0] EXC_ADDR   = 8'h28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_done,
  input  logic [COL_W-1:0]  tx_col_cnt,
  input  logic              tx_underrun,
  input  logic              tx_retry_lim,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ctl_wr_allow,
  input  logic              ctl_inc_stats
);

  frame_evt_t         fe;
  logic               multi_evt, exc_evt;
  logic               inc_prev, tst_pulse;
  logic               wr_ok;
  logic [MULTI_W-1:0] multi_cnt;
  logic [EXC_W-1:0]   exc_cnt;
  logic               multi_rd, multi_wr, exc_rd, exc_wr;

  txcol_classify #(.COL_W(COL_W)) u_cls (
    .tx_done      (tx_done),
    .tx_col_cnt   (tx_col_cnt),
    .tx_underrun  (tx_underrun),
    .tx_retry_lim (tx_retry_lim),
    .evt          (fe)
  );

  assign multi_evt = fe.multi;
  assign exc_evt   = fe.excess;
  assign wr_ok     = wr_en && ctl_wr_allow;

  // the test bit counts once per rising edge
  always_ff @(posedge clk) begin
    if (!rst_n) inc_prev <= 1'b0;
    else        inc_prev <= ctl_inc_stats;
  end
  assign tst_pulse = ctl_inc_stats && !inc_prev;

  txcol_sat_ctr #(.W(MULTI_W), .ADDR_W(ADDR_W), .ADDR(MULTI_ADDR)) u_multi (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt       (multi_evt),
    .tst_pulse (tst_pulse),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .wr_ok     (wr_ok),
    .wr_addr   (wr_addr),
    .wr_val    (wr_data[MULTI_W-1:0]),
    .cnt       (multi_cnt),
    .rd_hit    (multi_rd),
    .wr_hit    (multi_wr)
  );

  txcol_sat_ctr #(.W(EXC_W), .ADDR_W(ADDR_W), .ADDR(EXC_ADDR)) u_exc (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt       (exc_evt),
    .tst_pulse (tst_pulse),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .wr_ok     (wr_ok),
    .wr_addr   (wr_addr),
    .wr_val    (wr_data[EXC_W-1:0]),
    .cnt       (exc_cnt),
    .rd_hit    (exc_rd),
    .wr_hit    (exc_wr)
  );

  txcol_rdmux #(.DATA_W(DATA_W), .MULTI_W(MULTI_W), .EXC_W(EXC_W)) u_mux (
    .multi_hit (multi_rd),
    .multi_cnt (multi_cnt),
    .exc_hit   (exc_rd),
    .exc_cnt   (exc_cnt),
    .rd_data   (rd_data)
  );

endmodule

// File: rtl/txcol_stats_chk.sv
module txcol_stats_chk #(
  parameter int                MULTI_W    = 18,
  parameter int                EXC_W      = 10,
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] MULTI_ADDR = 8'h24,
  parameter logic [ADDR_W-1:0] EXC_ADDR   = 8'h28
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rd_en,
  input logic [ADDR_W-1:0]  rd_addr,
  input logic [31:0]        rd_data,
  input logic               wr_en,
  input logic               ctl_wr_allow,
  input logic [31:0]        wr_data,
  input logic               tst_pulse,
  input logic               multi_evt,
  input logic               exc_evt,
  input logic               multi_rd,
  input logic               multi_wr,
  input logic               exc_rd,
  input logic               exc_wr,
  input logic [MULTI_W-1:0] multi_cnt,
  input logic [EXC_W-1:0]   exc_cnt
);

  localparam logic [MULTI_W-1:0] M_MAX = '1;
  localparam logic [EXC_W-1:0]   E_MAX = '1;

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == MULTI_ADDR) |-> rd_data[31:MULTI_W] == '0); // R1

  AST_MULTI_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (multi_evt && !tst_pulse && !multi_rd && !multi_wr && multi_cnt != M_MAX)
    |=> multi_cnt == $past(multi_cnt) + 1'b1); // R2

  AST_MULTI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!multi_evt && !tst_pulse && !multi_rd && !multi_wr) |=> $stable(multi_cnt)); // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (multi_cnt == M_MAX && !multi_rd && !multi_wr) |=> multi_cnt == M_MAX); // R4

  AST_EXC_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_cnt == E_MAX && !exc_rd && !exc_wr) |=> exc_cnt == E_MAX); // R4

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (multi_rd && !multi_wr && !multi_evt && !tst_pulse) |=> multi_cnt == '0); // R5

  AST_WRITE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ctl_wr_allow && !multi_rd && !multi_evt && !tst_pulse)
    |=> $stable(multi_cnt)); // R6

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tst_pulse |=> !tst_pulse); // R7

  AST_READ_KEEPS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    (multi_rd && !multi_wr && (multi_evt ^ tst_pulse)) |=> multi_cnt == MULTI_W'(1)); // R9

  AST_EXC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_evt && !tst_pulse && !exc_rd && !exc_wr && exc_cnt != E_MAX)
    |=> exc_cnt == $past(exc_cnt) + 1'b1); // R10

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    multi_wr |=> multi_cnt == $past(wr_data[MULTI_W-1:0])); // R11

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr != MULTI_ADDR && rd_addr != EXC_ADDR) |-> rd_data == '0); // R12

endmodule

bind txcol_stats txcol_stats_chk #(
  .MULTI_W(MULTI_W), .EXC_W(EXC_W), .ADDR_W(ADDR_W),
  .MULTI_ADDR(MULTI_ADDR), .EXC_ADDR(EXC_ADDR)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_en        (rd_en),
  .rd_addr      (rd_addr),
  .rd_data      (rd_data),
  .wr_en        (wr_en),
  .ctl_wr_allow (ctl_wr_allow),
  .wr_data      (wr_data),
  .tst_pulse    (tst_pulse),
  .multi_evt    (multi_evt),
  .exc_evt      (exc_evt),
  .multi_rd     (multi_rd),
  .multi_wr     (multi_wr),
  .exc_rd       (exc_rd),
  .exc_wr       (exc_wr),
  .multi_cnt    (multi_cnt),
  .exc_cnt      (exc_cnt)
);

// File: tb/test_txcol_stats.sv
`timescale 1ns/1ps
module test_txcol_stats;

  localparam logic [7:0]  A_M   = 8'h24;
  localparam logic [7:0]  A_E   = 8'h28;
  localparam int unsigned M_TOP = 32'h3FFFF;
  localparam int unsigned E_TOP = 32'h3FF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tx_done, tx_underrun, tx_retry_lim;
  logic [4:0]  tx_col_cnt;
  logic        rd_en, wr_en, ctl_wr_allow, ctl_inc_stats;
  logic [7:0]  rd_addr, wr_addr;
  logic [31:0] wr_data, rd_data;

  int unsigned m_multi, m_exc;
  logic        m_prev;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done  = 1'b0;

  always #2 clk = ~clk;

  txcol_stats i_txcol_stats (
    .clk(clk), .rst_n(rst_n),
    .tx_done(tx_done), .tx_col_cnt(tx_col_cnt),
    .tx_underrun(tx_underrun), .tx_retry_lim(tx_retry_lim),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctl_wr_allow(ctl_wr_allow), .ctl_inc_stats(ctl_inc_stats)
  );

  function automatic bit good_multi();
    return tx_done && !tx_underrun && !tx_retry_lim &&
           (int'(tx_col_cnt) > 1) && (int'(tx_col_cnt) < 16);
  endfunction

  function automatic int unsigned bump(int unsigned v, int unsigned n, int unsigned top);
    return (v + n >= top) ? top : v + n;
  endfunction

  function automatic logic [31:0] exp_rd();
    if (!rd_en)       return 32'd0;
    if (rd_addr == A_M) return m_multi;
    if (rd_addr == A_E) return m_exc;
    return 32'd0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, expv);
    end
  endtask

  task automatic idle();
    tx_done = 0; tx_col_cnt = 0; tx_underrun = 0; tx_retry_lim = 0;
    rd_en = 0; rd_addr = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
    ctl_wr_allow = 0;
  endtask

  // evaluate the cycle just driven, then advance the model past the edge
  task automatic step(string tag);
    int unsigned pls, nm, ne;
    #1;
    if (rd_en) chk(tag, rd_data, exp_rd());
    pls = (ctl_inc_stats && !m_prev) ? 1 : 0;
    m_prev = ctl_inc_stats;
    nm = pls + (good_multi() ? 1 : 0);
    ne = pls + ((tx_done && tx_retry_lim) ? 1 : 0);
    if (wr_en && ctl_wr_allow && wr_addr == A_M) m_multi = wr_data & M_TOP;
    else if (rd_en && rd_addr == A_M)           m_multi = bump(0, nm, M_TOP);
    else                                         m_multi = bump(m_multi, nm, M_TOP);
    if (wr_en && ctl_wr_allow && wr_addr == A_E) m_exc = wr_data & E_TOP;
    else if (rd_en && rd_addr == A_E)           m_exc = bump(0, ne, E_TOP);
    else                                         m_exc = bump(m_exc, ne, E_TOP);
    @(negedge clk);
    idle();
  endtask

  task automatic rd(logic [7:0] a, string tag);
    rd_en = 1; rd_addr = a; step(tag);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, logic allow, string tag);
    wr_en = 1; wr_addr = a; wr_data = d; ctl_wr_allow = allow; step(tag);
  endtask

  task automatic frame(int col, logic ur, logic rl, string tag);
    tx_done = 1; tx_col_cnt = 5'(col); tx_underrun = ur; tx_retry_lim = rl; step(tag);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    idle(); ctl_inc_stats = 0; rst_n = 0;
    m_multi = 0; m_exc = 0; m_prev = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;

    rd(A_M, "R8 multi after reset"); rd(A_E, "R8 excess after reset");

    frame(3, 0, 0, "R2");
    rd(A_M, "R2 one good frame");
    rd(A_M, "R5 cleared by read");

    frame(1, 0, 0, "R3"); frame(16, 0, 0, "R3"); frame(5, 1, 0, "R3"); frame(15, 0, 1, "R3");
    tx_col_cnt = 5'd4; step("R3 no strobe");
    rd(A_M, "R3 bad frames ignored");
    rd(A_E, "R10 retry frame counted");

    wr(A_M, 32'd5, 0, "R6");
    rd(A_M, "R6 locked write ignored");
    wr(A_M, 32'hFFFF_FFFF, 1, "R1");
    frame(2, 0, 0, "R4");
    rd(A_M, "R1 R4 upper bits zero and saturated");
    wr(A_M, 32'h0003_FFFE, 1, "R4");
    frame(15, 0, 0, "R4"); frame(15, 0, 0, "R4");
    rd(A_M, "R4 stops at all ones");

    wr(A_M, 32'd7, 1, "R9");
    rd_en = 1; rd_addr = A_M; tx_done = 1; tx_col_cnt = 5'd6; step("R9 pre-event value");
    rd(A_M, "R9 event kept after clear");

    wr_en = 1; wr_addr = A_M; wr_data = 32'd9; ctl_wr_allow = 1;
    rd_en = 1; rd_addr = A_M; tx_done = 1; tx_col_cnt = 5'd2; step("R11 write with read and event");
    rd(A_M, "R11 write wins");

    ctl_inc_stats = 1; repeat (5) step("R7");
    ctl_inc_stats = 0;
    rd(A_M, "R7 multi single test increment");
    rd(A_E, "R7 excess single test increment");
    ctl_inc_stats = 1; tx_done = 1; tx_col_cnt = 5'd8; step("R7");
    ctl_inc_stats = 0;
    rd(A_M, "R7 event plus test adds two");

    wr(A_E, 32'hFFFF_FFFF, 1, "R10");
    frame(16, 0, 1, "R10");
    rd(A_E, "R4 R10 excess saturates");

    wr(A_M, 32'd4, 1, "R12");
    rd(8'h2C, "R12 unmapped reads zero");
    rd(A_M, "R12 counter untouched");

    for (int i = 0; i < 4000; i++) begin
      int sel;
      if ($urandom % 3 == 0) begin
        tx_done = 1; tx_col_cnt = 5'($urandom % 20);
        tx_underrun = ($urandom % 6 == 0); tx_retry_lim = ($urandom % 6 == 0);
      end
      if ($urandom % 4 == 0) begin
        sel = int'($urandom % 3);
        rd_en = 1; rd_addr = (sel == 0) ? A_M : (sel == 1) ? A_E : 8'($urandom);
      end
      if ($urandom % 20 == 0) begin
        wr_en = 1; wr_addr = ($urandom % 2 == 0) ? A_M : A_E;
        wr_data = ($urandom % 2 == 0) ? 32'hFFFF_FFFF - ($urandom % 4) : $urandom;
        ctl_wr_allow = ($urandom % 2 == 0);
      end
      if ($urandom % 16 == 0) ctl_inc_stats = ~ctl_inc_stats;
      step("R5 random read");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule